// File: doc/BRIEF.md
# Repeated Multiply-Accumulate Unit

This unit runs a multiply-accumulate loop whose operands live in memory. A start pulse loads two byte pointers, an iteration count and a 96-bit starting accumulator made of three 32-bit registers: top, middle and low. The top register is signed. On each iteration the unit fetches one signed operand from each pointer, sign-extends both from the selected size (byte, halfword or word), multiplies them, and adds the 64-bit signed product into the accumulator. A carry or borrow out of the lower 64 bits moves into the top register. Both pointers then advance by the operand size in bytes, and the count drops by one.

When the count reaches zero, the unit records a sign flag and an overflow flag. The overflow flag means the top register holds more than a sign extension of the lower 64 bits. A separate saturate command uses these flags. If overflow is set, it clamps the accumulator to the largest positive or the most negative 64-bit value, chosen by the sign flag. If overflow is clear, it has no effect. Operands are fetched through a read-only request port with a valid/ready handshake. Read data returns later with its own valid strobe, little-endian, in the low bits of the data word.

Top module: `rmac_unit`

## Requirements
- R1: After reset, the pointers, count, all three accumulator registers, the sign and overflow flags, `rdValid`, `busy` and `done` are all zero.
- R2: A start with `initCount` = 0 loads the initial values onto the register outputs. It issues no read and leaves both flags unchanged. It raises `done` in the cycle after start, and `busy` stays low.
- R3: Each iteration makes two reads, first at pointer A and then at pointer B. A request keeps `rdValid` high and `rdAddr` stable until `rdReady` is seen. A count of N gives exactly 2N accepted requests.
- R4: Size code 0 takes the low 8 bits of read data. Code 1 takes the low 16 bits. Code 2 takes all 32 bits, and code 3 behaves as code 2. The chosen bits are sign-extended before the multiply.
- R5: Both pointers advance by 1, 2 or 4 bytes per iteration (4 for codes 2 and 3), and the count decrements once per iteration to zero.
- R6: The final value {top, middle, low} equals the initial 96-bit signed value plus the sum of all products, modulo 2^96. This means a carry out of the low 64 bits increments top for a non-negative product, and a missing carry decrements top for a negative product.
- R7: At completion, the sign flag equals bit 31 of top. The overflow flag is set exactly when top is neither 0x00000000 nor 0xFFFFFFFF.
- R8: A start with a non-zero count clears the overflow flag in its first cycle, and the flag stays clear while `busy` is high.
- R9: `done` is a one-cycle pulse issued one cycle after the final accumulation, with `busy` low.
- R10: A saturate command while idle with overflow set loads 00000000:7FFFFFFF:FFFFFFFF when the sign flag is 1. It loads FFFFFFFF:80000000:00000000 when the sign flag is 0. The flags are unchanged.
- R11: A saturate command with overflow clear leaves all three accumulator registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin an operation (taken while idle) |
| sizeCode | input | 2 | Operand size: 0 byte, 1 half, 2/3 word |
| satPulse | input | 1 | Saturate command (taken while idle) |
| initPtrA | input | 32 | Starting byte address of operand stream A |
| initPtrB | input | 32 | Starting byte address of operand stream B |
| initCount | input | 32 | Number of iterations |
| initLow | input | 32 | Starting accumulator low word |
| initMid | input | 32 | Starting accumulator middle word |
| initTop | input | 32 | Starting accumulator top word (signed) |
| rdValid | output | 1 | Read request valid |
| rdAddr | output | 32 | Read request byte address |
| rdReady | input | 1 | Read request accepted |
| rspValid | input | 1 | Read data valid |
| rspData | input | 32 | Read data, little-endian, low bits used |
| ptrA | output | 32 | Current pointer A |
| ptrB | output | 32 | Current pointer B |
| count | output | 32 | Remaining iterations |
| accLow | output | 32 | Accumulator low word |
| accMid | output | 32 | Accumulator middle word |
| accTop | output | 32 | Accumulator top word |
| flagSign | output | 1 | Sign flag |
| flagOvf | output | 1 | Overflow flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
The bench builds the unit with its default 32-bit register width. At that width, full-word operands give products near 2^62, so a few iterations are enough to carry into or borrow from the top word. The starting values in the vector table are chosen near 64-bit boundaries so that both directions occur, along with top words that leave the overflow flag set with either sign. A memory responder that stalls the request handshake on a fixed pattern keeps the address-hold rule and the read ordering under load.

// File: rtl/rmac_pkg.sv
package rmac_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef struct packed {
    logic loadInit;
    logic clrOvf;
    logic selB;
    logic capA;
    logic capB;
    logic step;
    logic setFlags;
    logic saturate;
  } ctrl_s;

endpackage

// File: rtl/rmac_accum.sv
module rmac_accum #(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0]   lowIn,
  input  logic [REG_W-1:0]   midIn,
  input  logic [REG_W-1:0]   topIn,
  input  logic [2*REG_W-1:0] prod,
  output logic [REG_W-1:0]   lowOut,
  output logic [REG_W-1:0]   midOut,
  output logic [REG_W-1:0]   topOut
);
  localparam int PROD_W = 2 * REG_W;

  logic [PROD_W:0]  wideSum;
  logic             carryOut;
  logic [REG_W-1:0] topAdj;

  // lower 64 bits add with an explicit carry out
  assign wideSum  = {1'b0, midIn, lowIn} + {1'b0, prod};
  assign carryOut = wideSum[PROD_W];
  // top word absorbs the sign extension of the product plus the carry
  assign topAdj   = {REG_W{prod[PROD_W-1]}} + REG_W'(carryOut);

  assign lowOut = wideSum[REG_W-1:0];
  assign midOut = wideSum[PROD_W-1:REG_W];
  assign topOut = topIn + topAdj;
endmodule

// File: rtl/rmac_ctrl.sv
module rmac_ctrl
  import rmac_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  startPulse,
  input  logic  satPulse,
  input  logic  initCountZero,
  input  logic  lastIter,
  input  logic  rdReady,
  input  logic  rspValid,
  output ctrl_s strobes,
  output logic  rdValid,
  output logic  busy,
  output logic  done
);
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQA  = 3'd1,
    ST_WAITA = 3'd2,
    ST_REQB  = 3'd3,
    ST_WAITB = 3'd4,
    ST_ACC   = 3'd5
  } state_e;

  state_e state, stateNext;
  logic   doneNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    rdValid   = 1'b0;
    doneNext  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobes.loadInit = 1'b1;
          if (initCountZero) begin
            doneNext = 1'b1;
          end else begin
            strobes.clrOvf = 1'b1;
            stateNext      = ST_REQA;
          end
        end else if (satPulse) begin
          strobes.saturate = 1'b1;
        end
      end
      ST_REQA: begin
        rdValid = 1'b1;
        if (rdReady) stateNext = ST_WAITA;
      end
      ST_WAITA: begin
        if (rspValid) begin
          strobes.capA = 1'b1;
          stateNext    = ST_REQB;
        end
      end
      ST_REQB: begin
        rdValid      = 1'b1;
        strobes.selB = 1'b1;
        if (rdReady) stateNext = ST_WAITB;
      end
      ST_WAITB: begin
        if (rspValid) begin
          strobes.capB = 1'b1;
          stateNext    = ST_ACC;
        end
      end
      ST_ACC: begin
        strobes.step = 1'b1;
        if (lastIter) begin
          strobes.setFlags = 1'b1;
          doneNext         = 1'b1;
          stateNext        = ST_IDLE;
        end else begin
          stateNext = ST_REQA;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/rmac_dpath.sv
module rmac_dpath
  import rmac_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_s            strobes,
  input  logic [1:0]       sizeCode,
  input  logic [REG_W-1:0] initPtrA,
  input  logic [REG_W-1:0] initPtrB,
  input  logic [REG_W-1:0] initCount,
  input  logic [REG_W-1:0] initLow,
  input  logic [REG_W-1:0] initMid,
  input  logic [REG_W-1:0] initTop,
  input  logic [REG_W-1:0] rspData,
  output logic [REG_W-1:0] rdAddr,
  output logic [REG_W-1:0] ptrA,
  output logic [REG_W-1:0] ptrB,
  output logic [REG_W-1:0] count,
  output logic [REG_W-1:0] accLow,
  output logic [REG_W-1:0] accMid,
  output logic [REG_W-1:0] accTop,
  output logic             flagSign,
  output logic             flagOvf,
  output logic             lastIter
);
  localparam int PROD_W     = 2 * REG_W;
  localparam int WORD_BYTES = REG_W / 8;

  localparam logic [REG_W-1:0] SAT_POS_TOP = '0;
  localparam logic [REG_W-1:0] SAT_POS_MID = {1'b0, {(REG_W-1){1'b1}}};
  localparam logic [REG_W-1:0] SAT_POS_LOW = '1;
  localparam logic [REG_W-1:0] SAT_NEG_TOP = '1;
  localparam logic [REG_W-1:0] SAT_NEG_MID = {1'b1, {(REG_W-1){1'b0}}};
  localparam logic [REG_W-1:0] SAT_NEG_LOW = '0;

  size_e               sizeReg;
  logic [REG_W-1:0]    opA, opB;
  logic [REG_W-1:0]    stepBytes;
  logic signed [PROD_W-1:0] opAx, opBx, prod;
  logic [REG_W-1:0]    lowSum, midSum, topSum;
  logic                ovfNext;

  function automatic logic [REG_W-1:0] extend(input logic [REG_W-1:0] raw,
                                               input size_e sz);
    case (sz)
      SZ_BYTE: extend = {{(REG_W-8){raw[7]}}, raw[7:0]};
      SZ_HALF: extend = {{(REG_W-16){raw[15]}}, raw[15:0]};
      default: extend = raw;
    endcase
  endfunction

  always_comb begin
    case (sizeReg)
      SZ_BYTE: stepBytes = REG_W'(1);
      SZ_HALF: stepBytes = REG_W'(2);
      default: stepBytes = REG_W'(WORD_BYTES);
    endcase
  end

  assign opAx = {{REG_W{opA[REG_W-1]}}, opA};
  assign opBx = {{REG_W{opB[REG_W-1]}}, opB};
  assign prod = opAx * opBx;

  rmac_accum #(.REG_W(REG_W)) u_accum (
    .lowIn  (accLow),
    .midIn  (accMid),
    .topIn  (accTop),
    .prod   (prod),
    .lowOut (lowSum),
    .midOut (midSum),
    .topOut (topSum)
  );

  assign ovfNext  = (topSum != '0) && (topSum != '1);
  assign rdAddr   = strobes.selB ? ptrB : ptrA;
  assign lastIter = (count == REG_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeReg  <= SZ_BYTE;
      opA      <= '0;
      opB      <= '0;
      ptrA     <= '0;
      ptrB     <= '0;
      count    <= '0;
      accLow   <= '0;
      accMid   <= '0;
      accTop   <= '0;
      flagSign <= 1'b0;
      flagOvf  <= 1'b0;
    end else begin
      if (strobes.loadInit) begin
        sizeReg <= size_e'(sizeCode);
        ptrA    <= initPtrA;
        ptrB    <= initPtrB;
        count   <= initCount;
        accLow  <= initLow;
        accMid  <= initMid;
        accTop  <= initTop;
      end
      if (strobes.clrOvf) flagOvf <= 1'b0;
      if (strobes.capA)   opA <= extend(rspData, sizeReg);
      if (strobes.capB)   opB <= extend(rspData, sizeReg);
      if (strobes.step) begin
        ptrA   <= ptrA + stepBytes;
        ptrB   <= ptrB + stepBytes;
        count  <= count - REG_W'(1);
        accLow <= lowSum;
        accMid <= midSum;
        accTop <= topSum;
      end
      if (strobes.setFlags) begin
        flagSign <= topSum[REG_W-1];
        flagOvf  <= ovfNext;
      end
      if (strobes.saturate && flagOvf) begin
        if (flagSign) begin
          accTop <= SAT_POS_TOP;
          accMid <= SAT_POS_MID;
          accLow <= SAT_POS_LOW;
        end else begin
          accTop <= SAT_NEG_TOP;
          accMid <= SAT_NEG_MID;
          accLow <= SAT_NEG_LOW;
        end
      end
    end
  end
endmodule

// File: rtl/rmac_unit.sv
module rmac_unit
  import rmac_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [1:0]       sizeCode,
  input  logic             satPulse,
  input  logic [REG_W-1:0] initPtrA,
  input  logic [REG_W-1:0] initPtrB,
  input  logic [REG_W-1:0] initCount,
  input  logic [REG_W-1:0] initLow,
  input  logic [REG_W-1:0] initMid,
  input  logic [REG_W-1:0] initTop,
  output logic             rdValid,
  output logic [REG_W-1:0] rdAddr,
  input  logic             rdReady,
  input  logic             rspValid,
  input  logic [REG_W-1:0] rspData,
  output logic [REG_W-1:0] ptrA,
  output logic [REG_W-1:0] ptrB,
  output logic [REG_W-1:0] count,
  output logic [REG_W-1:0] accLow,
  output logic [REG_W-1:0] accMid,
  output logic [REG_W-1:0] accTop,
  output logic             flagSign,
  output logic             flagOvf,
  output logic             busy,
  output logic             done
);
  ctrl_s strobes;
  logic  lastIter;
  logic  initCountZero;

  assign initCountZero = (initCount == '0);

  rmac_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .startPulse    (startPulse),
    .satPulse      (satPulse),
    .initCountZero (initCountZero),
    .lastIter      (lastIter),
    .rdReady       (rdReady),
    .rspValid      (rspValid),
    .strobes       (strobes),
    .rdValid       (rdValid),
    .busy          (busy),
    .done          (done)
  );

  rmac_dpath #(.REG_W(REG_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sizeCode  (sizeCode),
    .initPtrA  (initPtrA),
    .initPtrB  (initPtrB),
    .initCount (initCount),
    .initLow   (initLow),
    .initMid   (initMid),
    .initTop   (initTop),
    .rspData   (rspData),
    .rdAddr    (rdAddr),
    .ptrA      (ptrA),
    .ptrB      (ptrB),
    .count     (count),
    .accLow    (accLow),
    .accMid    (accMid),
    .accTop    (accTop),
    .flagSign  (flagSign),
    .flagOvf   (flagOvf),
    .lastIter  (lastIter)
  );
endmodule

// File: rtl/rmac_chk.sv
module rmac_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             satPulse,
  input logic             rdValid,
  input logic             rdReady,
  input logic [REG_W-1:0] rdAddr,
  input logic [REG_W-1:0] count,
  input logic [REG_W-1:0] accLow,
  input logic [REG_W-1:0] accMid,
  input logic [REG_W-1:0] accTop,
  input logic             flagOvf,
  input logic             busy,
  input logic             done
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid && $stable(rdAddr));

  assert_req_in_op_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> busy);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && !$stable(count) |-> count == $past(count) - REG_W'(1));

  assert_ovf_low_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !flagOvf);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_sat_clamp_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy && satPulse && !startPulse && flagOvf |=> (accTop == '0 || accTop == '1));

  assert_sat_noop_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy && satPulse && !startPulse && !flagOvf
      |=> $stable(accTop) && $stable(accMid) && $stable(accLow));
endmodule

bind rmac_unit rmac_chk #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .satPulse   (satPulse),
  .rdValid    (rdValid),
  .rdReady    (rdReady),
  .rdAddr     (rdAddr),
  .count      (count),
  .accLow     (accLow),
  .accMid     (accMid),
  .accTop     (accTop),
  .flagOvf    (flagOvf),
  .busy       (busy),
  .done       (done)
);

// File: tb/sim_rmac_unit.sv
module sim_rmac_unit;
  localparam int REG_W = 32;
  localparam int NVEC  = 7;
  // {size[1:0], ptrA, ptrB, count[7:0], top, mid, low}
  localparam int VEC_W = 2 + 32 + 32 + 8 + 96;
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {2'd0, 32'h0000_0100, 32'h0000_0200, 8'd5, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {2'd1, 32'h0000_0031, 32'h0000_0400, 8'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FF00},
    {2'd2, 32'h0000_1000, 32'h0000_2003, 8'd4, 32'h0000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFF0},
    {2'd2, 32'h0000_0A10, 32'h0000_0B20, 8'd3, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678},
    {2'd3, 32'h0000_0C01, 32'h0000_0D02, 8'd2, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0004},
    {2'd0, 32'h0000_00F0, 32'h0000_0070, 8'd1, 32'h1234_5678, 32'hAAAA_AAAA, 32'h5555_5555},
    {2'd2, 32'h0000_3000, 32'h0000_3100, 8'd6, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic [1:0]       sizeCode = 2'd0;
  logic             satPulse = 1'b0;
  logic [REG_W-1:0] initPtrA = '0, initPtrB = '0, initCount = '0;
  logic [REG_W-1:0] initLow = '0, initMid = '0, initTop = '0;
  logic             rdValid, rdReady;
  logic [REG_W-1:0] rdAddr;
  logic             rspValid;
  logic [REG_W-1:0] rspData;
  logic [REG_W-1:0] ptrA, ptrB, count, accLow, accMid, accTop;
  logic             flagSign, flagOvf, busy, done;

  int checks = 0;
  int errors = 0;
  logic [31:0] cyc;
  int          hsCount;
  logic [31:0] addrLog [64];

  always #10 clk = ~clk;

  rmac_unit #(.REG_W(REG_W)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .sizeCode(sizeCode),
    .satPulse(satPulse), .initPtrA(initPtrA), .initPtrB(initPtrB),
    .initCount(initCount), .initLow(initLow), .initMid(initMid),
    .initTop(initTop), .rdValid(rdValid), .rdAddr(rdAddr), .rdReady(rdReady),
    .rspValid(rspValid), .rspData(rspData), .ptrA(ptrA), .ptrB(ptrB),
    .count(count), .accLow(accLow), .accMid(accMid), .accTop(accTop),
    .flagSign(flagSign), .flagOvf(flagOvf), .busy(busy), .done(done)
  );

  function automatic logic [7:0] memByte(input logic [31:0] a);
    logic [31:0] m;
    m = a * 32'd29 + (a >> 8) * 32'd7;
    return m[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {memByte(a + 32'd3), memByte(a + 32'd2), memByte(a + 32'd1), memByte(a)};
  endfunction

  // memory responder: stalls one cycle in four, answers one cycle after acceptance
  assign rdReady = (cyc[1:0] != 2'b11);
  always @(posedge clk) begin
    if (!rstN) begin
      cyc      <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
      hsCount  <= 0;
    end else begin
      cyc      <= cyc + 32'd1;
      rspValid <= 1'b0;
      if (rdValid && rdReady) begin
        rspValid               <= 1'b1;
        rspData                <= memWord(rdAddr);
        addrLog[hsCount % 64]  <= rdAddr;
        hsCount                <= hsCount + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [95:0] act,
                     input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic signed [31:0] extendOp(input logic [31:0] raw,
                                                  input logic [1:0] sz);
    case (sz)
      2'd0:    return {{24{raw[7]}}, raw[7:0]};
      2'd1:    return {{16{raw[15]}}, raw[15:0]};
      default: return raw;
    endcase
  endfunction

  task automatic runOp(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic [31:0] tp,
                       input logic [31:0] mi, input logic [31:0] lo);
    int base, guard;
    logic prevS, prevO;
    logic [31:0] stepB, expTop;
    logic signed [95:0] acc;
    logic signed [63:0] pa, pb, pr;
    prevS = flagSign;
    prevO = flagOvf;
    base  = hsCount;
    sizeCode = sz; initPtrA = a; initPtrB = b; initCount = c;
    initTop = tp; initMid = mi; initLow = lo;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (c != 0) begin
      // R8: overflow cleared in first busy cycle
      chk(busy && !flagOvf, "R8 ovf clear at start", {94'd0, busy, flagOvf}, 96'd2);
    end
    guard = 0;
    while (!done && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, "R9 done seen", {95'd0, done}, 96'd1);
    stepB = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    acc = {tp, mi, lo};
    for (int i = 0; i < int'(c); i++) begin
      pa  = 64'(extendOp(memWord(a + stepB * i), sz));
      pb  = 64'(extendOp(memWord(b + stepB * i), sz));
      pr  = pa * pb;
      acc = acc + 96'(pr);
    end
    expTop = acc[95:64];
    if (c == 0) begin
      chk(!busy, "R2 stays idle", {95'd0, busy}, 96'd0);
      chk(hsCount == base, "R2 no read", 96'(hsCount - base), 96'd0);
      chk({flagSign, flagOvf} == {prevS, prevO}, "R2 flags kept",
          {94'd0, flagSign, flagOvf}, {94'd0, prevS, prevO});
      chk({accTop, accMid, accLow} == {tp, mi, lo}, "R2 regs loaded",
          {accTop, accMid, accLow}, {tp, mi, lo});
      chk({ptrA, ptrB, count} == {a, b, c}, "R2 ptrs loaded",
          {ptrA, ptrB, count}, {a, b, c});
    end else begin
      chk({accTop, accMid, accLow} == acc, "R4,R6 accumulator",
          {accTop, accMid, accLow}, acc);
      chk(ptrA == a + stepB * c && ptrB == b + stepB * c, "R5 pointers",
          {32'd0, ptrA, ptrB}, {32'd0, a + stepB * c, b + stepB * c});
      chk(count == 0, "R5 count", 96'(count), 96'd0);
      chk(flagSign == expTop[31] && flagOvf == (expTop != 0 && expTop != '1),
          "R7 flags", {94'd0, flagSign, flagOvf},
          {94'd0, expTop[31], (expTop != 0 && expTop != '1)});
      chk(hsCount - base == 2 * int'(c), "R3 read count",
          96'(hsCount - base), 96'(2 * c));
      chk(addrLog[base % 64] == a && addrLog[(base + 1) % 64] == b, "R3 read order",
          {32'd0, addrLog[base % 64], addrLog[(base + 1) % 64]}, {32'd0, a, b});
      if (c > 1)
        chk(addrLog[(base + 2) % 64] == a + stepB, "R3 second A read",
            96'(addrLog[(base + 2) % 64]), 96'(a + stepB));
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 single pulse", {95'd0, done}, 96'd0);
  endtask

  task automatic saturate(input logic [95:0] expAcc, input string req);
    logic s0, o0;
    s0 = flagSign; o0 = flagOvf;
    satPulse = 1'b1;
    @(negedge clk);
    satPulse = 1'b0;
    chk({accTop, accMid, accLow} == expAcc, req, {accTop, accMid, accLow}, expAcc);
    chk({flagSign, flagOvf} == {s0, o0}, "R10 flags kept by saturate",
        {94'd0, flagSign, flagOvf}, {94'd0, s0, o0});
  endtask

  initial begin
    logic [95:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({ptrA, ptrB, count} == '0, "R1 ptrs/count", {ptrA, ptrB, count}, 96'd0);
    chk({accTop, accMid, accLow} == '0, "R1 accumulator", {accTop, accMid, accLow}, 96'd0);
    chk({flagSign, flagOvf, rdValid, busy, done} == '0, "R1 control",
        96'({flagSign, flagOvf, rdValid, busy, done}), 96'd0);

    for (int v = 0; v < NVEC; v++) begin
      runOp(VECS[v][VEC_W-1 -: 2], VECS[v][VEC_W-3 -: 32], VECS[v][VEC_W-35 -: 32],
            {24'd0, VECS[v][VEC_W-67 -: 8]}, VECS[v][95:64], VECS[v][63:32], VECS[v][31:0]);
    end

    // R2: zero count after a run leaving S=0, O=1
    runOp(2'd0, 32'h40, 32'h80, 32'd2, 32'h1234_5678, 32'd0, 32'd0);
    runOp(2'd1, 32'h55, 32'h66, 32'd0, 32'h0, 32'h0000_0001, 32'h0000_0002);
    // R10: O=1, S=0 -> most negative pattern
    saturate({32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0000}, "R10 clamp negative");
    // R10: O=1, S=1 -> largest positive pattern
    runOp(2'd0, 32'h90, 32'hA0, 32'd1, 32'h8000_0005, 32'd0, 32'd0);
    saturate({32'h0000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF}, "R10 clamp positive");
    // R11: O clear, no change
    runOp(2'd0, 32'h10, 32'h20, 32'd2, 32'd0, 32'h0000_1234, 32'h89AB_CDEF);
    held = {accTop, accMid, accLow};
    saturate(held, "R11 saturate without overflow");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule